// File: doc/BRIEF.md
# Shift-Add Two-Value Blender

This block mixes two unsigned samples, A and B, at a weight set by a small selector code. It uses no multiplier. Each of four terms takes either A or B, as chosen by the code. The term is then shifted right to a fixed binary weight. The weights are one half, one quarter, one eighth and one eighth. The four shifted terms are added together. The total is computed with extra headroom and then clamped to the largest value the output can hold. The output is registered, so a result appears one clock after its inputs are presented with the valid flag.

A mode input chooses how the selector is read. In quad mode, each of the four selector bits chooses the operand for one term. The fine mode gives eighth-step weights from a two-bit code. In that mode the two eighth-weight terms are fixed at A and at B, so the code steps the blend from 1/8 A up to 7/8 A in quarter steps. Every term is truncated on its own, so the result can sit a few LSB below the exact weighted value.

Top module: `shift_add_blender`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid` is 0 and `out_data` is 0.
- R2: `out_valid` equals `in_valid` delayed by exactly one clock, including when valid is held high on consecutive cycles.
- R3: With `in_mode` = 1 (quad mode), the result is the sum of four terms, each truncated by its own shift. The terms are (sel[3] ? A : B) >> 1, (sel[2] ? A : B) >> 2, (sel[1] ? A : B) >> 3 and (sel[0] ? A : B) >> 3.
- R4: With `in_mode` = 0 (fine mode), the result is (sel[1] ? A : B) >> 1 + (sel[0] ? A : B) >> 2 + (A >> 3) + (B >> 3). Codes 00, 01, 10 and 11 on sel[1:0] give about 1/8, 3/8, 5/8 and 7/8 of A, with the rest taken from B.
- R5: In fine mode, sel[3:2] has no effect on the result.
- R6: When A equals B, the result is never above A and never more than 3 LSB below A.
- R7: A result is captured only in a cycle where `in_valid` is 1. In all other cycles `out_data` keeps its value.
- R8: The sum is formed two bits wider than the data and clamped to 2^DATA_W-1. It never wraps. With A = B = 4095 the result is 4092.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample qualifier |
| in_mode | input | 1 | 1 = quad mode (four-bit code), 0 = fine mode (two-bit code) |
| in_sel | input | 4 | Blend code |
| in_a | input | DATA_W (12) | Operand A |
| in_b | input | DATA_W (12) | Operand B |
| out_valid | output | 1 | Result qualifier, one cycle after `in_valid` |
| out_data | output | DATA_W (12) | Blended result |

## Verification
The datapath holds only one stage of state. A wrong term routing or shift shows up at `out_data` on the very next clock. It appears as a value off by a whole weighted term, not a small truncation error. The bench uses operand pairs with one side zero, such as A = 800 with B = 0 and the reverse, so that each term's choice and weight can be read directly from the result. Faults in the valid pipeline or the capture enable show up one cycle later. They appear as a missing or extra `out_valid` pulse, or as `out_data` changing while `in_valid` was low.

// File: rtl/blend_pkg.sv
package blend_pkg;

    localparam int NUM_TERMS = 4;
    localparam int SEL_W     = 4;

    typedef enum logic {
        MODE_FINE = 1'b0,
        MODE_QUAD = 1'b1
    } blend_mode_e;

    // Right-shift amount giving each term its binary weight.
    function automatic int term_shift(input int idx);
        case (idx)
            0:       return 1;
            1:       return 2;
            default: return 3;
        endcase
    endfunction

    // Returns 1 when term idx takes operand A, 0 when it takes B.
    function automatic logic term_takes_a(input blend_mode_e mode,
                                          input logic [SEL_W-1:0] sel,
                                          input int idx);
        if (mode == MODE_QUAD) begin
            return sel[SEL_W-1-idx];
        end
        case (idx)
            0:       return sel[1];
            1:       return sel[0];
            2:       return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/blend_term_sel.sv
module blend_term_sel
    import blend_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  blend_mode_e                             mode,
    input  logic [SEL_W-1:0]                        sel,
    input  logic [DATA_W-1:0]                       a,
    input  logic [DATA_W-1:0]                       b,
    output logic [NUM_TERMS-1:0][DATA_W-1:0]        terms
);

    for (genvar i = 0; i < NUM_TERMS; i++) begin : g_term
        logic [DATA_W-1:0] pick;
        always_comb begin
            pick     = term_takes_a(mode, sel, i) ? a : b;
            terms[i] = pick >> term_shift(i);
        end
    end

endmodule

// File: rtl/blend_sum_sat.sv
module blend_sum_sat
    import blend_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic [NUM_TERMS-1:0][DATA_W-1:0] terms,
    output logic [DATA_W-1:0]                result
);

    localparam int SUM_W = DATA_W + $clog2(NUM_TERMS);
    localparam logic [SUM_W-1:0] LIMIT = SUM_W'((1 << DATA_W) - 1);

    logic [SUM_W-1:0] total;

    always_comb begin
        total = '0;
        for (int i = 0; i < NUM_TERMS; i++) begin
            total = total + SUM_W'(terms[i]);
        end
        result = (total > LIMIT) ? LIMIT[DATA_W-1:0] : total[DATA_W-1:0];
    end

endmodule

// File: rtl/shift_add_blender.sv
module shift_add_blender
    import blend_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_mode,
    input  logic [3:0]        in_sel,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    localparam int CMP_W = DATA_W + 2;

    logic [NUM_TERMS-1:0][DATA_W-1:0] terms;
    logic [DATA_W-1:0]                blended;
    blend_mode_e                      mode;

    assign mode = blend_mode_e'(in_mode);

    blend_term_sel #(.DATA_W(DATA_W)) u_terms (
        .mode  (mode),
        .sel   (in_sel),
        .a     (in_a),
        .b     (in_b),
        .terms (terms)
    );

    blend_sum_sat #(.DATA_W(DATA_W)) u_sum (
        .terms  (terms),
        .result (blended)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= blended;
            end
        end
    end

    // R2: valid pipeline
    a_r2_valid_rise: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r2_valid_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R7: no capture without valid
    a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));
    // R6: equal operands stay within truncation bound
    a_r6_equal_inputs: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_a == in_b) |=>
        ((CMP_W'(out_data) <= CMP_W'($past(in_a))) &&
         (CMP_W'(out_data) + CMP_W'(3) >= CMP_W'($past(in_a)))));

endmodule

// File: tb/shift_add_blender_bench.sv
`timescale 1ns/1ps
module shift_add_blender_bench;

    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic          in_mode;
    logic [3:0]    in_sel;
    logic [DW-1:0] in_a;
    logic [DW-1:0] in_b;
    logic          out_valid;
    logic [DW-1:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    shift_add_blender #(.DATA_W(DW)) u_shift_add_blender (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
        .in_sel(in_sel), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic int model(input bit quad, input logic [3:0] s,
                                 input int a, input int b);
        int r;
        if (quad)
            r = ((s[3] ? a : b) >> 1) + ((s[2] ? a : b) >> 2)
              + ((s[1] ? a : b) >> 3) + ((s[0] ? a : b) >> 3);
        else
            r = ((s[1] ? a : b) >> 1) + ((s[0] ? a : b) >> 2)
              + (a >> 3) + (b >> 3);
        return (r > 4095) ? 4095 : r;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Present one sample at a falling edge, check the result one clock later.
    task automatic apply(input string req, input bit quad, input logic [3:0] s,
                         input int a, input int b, input int exp);
        @(negedge clk);
        in_valid = 1'b1; in_mode = quad; in_sel = s;
        in_a = DW'(a); in_b = DW'(b);
        @(negedge clk);
        in_valid = 1'b0;
        check(req, int'(out_data), exp);
        check({req, " valid"}, int'(out_valid), 1);
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; in_mode = 1'b0; in_sel = '0;
        in_a = '0; in_b = '0;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", int'(out_valid), 0);
        check("R1 data in reset", int'(out_data), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", int'(out_valid), 0);
        check("R1 data after reset", int'(out_data), 0);
    endtask

    task automatic t_quad();
        apply("R3 all A", 1, 4'b1111, 800, 0, 800);
        apply("R3 half A", 1, 4'b1000, 800, 0, 400);
        apply("R3 quarter A", 1, 4'b0100, 800, 0, 200);
        apply("R3 eighth A bit1", 1, 4'b0010, 800, 0, 100);
        apply("R3 eighth A bit0", 1, 4'b0001, 800, 0, 100);
        apply("R3 mixed", 1, 4'b1010, 1000, 3000, model(1, 4'b1010, 1000, 3000));
    endtask

    task automatic t_fine();
        apply("R4 code00", 0, 4'b0000, 800, 0, 100);
        apply("R4 code01", 0, 4'b0001, 800, 0, 300);
        apply("R4 code10", 0, 4'b0010, 800, 0, 500);
        apply("R4 code11", 0, 4'b0011, 800, 0, 700);
        apply("R4 code00 B side", 0, 4'b0000, 0, 800, 700);
        apply("R4 mixed", 0, 4'b0010, 123, 3999, model(0, 4'b0010, 123, 3999));
    endtask

    task automatic t_fine_upper();
        apply("R5 upper bits 11", 0, 4'b1101, 800, 0, 300);
        apply("R5 upper bits 10", 0, 4'b1000, 0, 800, 700);
    endtask

    task automatic t_equal();
        apply("R6 equal 800", 1, 4'b0110, 800, 800, 800);
        apply("R6 equal 1001", 0, 4'b0001, 1001, 1001, model(0, 4'b0001, 1001, 1001));
        apply("R8 full scale", 1, 4'b1111, 4095, 4095, 4092);
        apply("R8 full scale fine", 0, 4'b0011, 4095, 4095, 4092);
    endtask

    task automatic t_hold();
        apply("R7 load", 1, 4'b1111, 640, 0, 640);
        @(negedge clk);
        in_valid = 1'b0; in_mode = 1'b1; in_sel = 4'b1111; in_a = 12'd200;
        @(negedge clk);
        check("R7 data held", int'(out_data), 640);
        check("R2 valid low", int'(out_valid), 0);
    endtask

    task automatic t_stream();
        @(negedge clk);
        for (int k = 0; k < 5; k++) begin
            in_valid = 1'b1; in_mode = 1'b1; in_sel = 4'b1000;
            in_a = DW'(100 * (k + 2)); in_b = '0;
            @(negedge clk);
            check("R2 stream valid", int'(out_valid), 1);
            check("R2 stream data", int'(out_data), 50 * (k + 2));
        end
        in_valid = 1'b0;
        @(negedge clk);
        check("R2 stream end", int'(out_valid), 0);
    endtask

    initial begin
        t_reset();
        t_quad();
        t_fine();
        t_fine_upper();
        t_equal();
        t_hold();
        t_stream();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule